// File: doc/BRIEF.md
# Per-Channel Window Alarm Monitor

This block watches a stream of finished analog-to-digital conversion results. Each result arrives with a channel tag. For every channel the block keeps two limits, a lower one and an upper one. When monitoring is switched on, each result is checked against the limits of its own channel. A result outside the window sets a sticky fault bit for that channel. While any fault bit is set, the block enables an open-drain pull-down on the shared, active-low alert line.

The host side of the chip writes and reads the limits through a simple port: channel, upper-or-lower select and value. It clears faults with a per-channel mask, for example after servicing an alert-response read. The limits live in flops and are loaded at reset with an all-pass window. Because of that, a channel never trips until software narrows its limits. An unconnected input therefore needs no special handling beyond its limits.

Top module: `window_alarm_monitor`

## Requirements
- R1: After reset every upper limit is all ones (1023 for 10 bits), every lower limit is 0, `faultStatus` is 0 and `alertOe` is 0.
- R2: A cycle with `limWrEn`=1 and `limWrChan` below the channel count writes `limWrData` to that channel's upper limit when `limWrUpper`=1, or to its lower limit when `limWrUpper`=0. The new value appears on `limRdData` in the cycle after the write.
- R3: A limit write whose `limWrChan` is not below the channel count changes no limit. A read with such a `limRdChan` returns 0.
- R4: With `monitorEn`=1, a valid result strictly above the upper limit, or strictly below the lower limit, of its channel sets that channel's bit of `faultStatus` in the cycle after `convValid`.
- R5: A result equal to its channel's upper limit or to its lower limit sets no fault.
- R6: While `monitorEn`=0, results set no fault, and faults already latched keep their value.
- R7: A result whose `convChan` is not below the channel count sets no fault on any channel.
- R8: A fault bit stays set until a cycle with `clrEn`=1 and the matching `clrMask` bit set (bit i is channel i). Such a cycle clears only the masked channels.
- R9: If a fault sets for a channel in the same cycle that its clear is requested, the fault stays set.
- R10: `alertOe` is 1, meaning the shared line is pulled low, exactly when at least one `faultStatus` bit is set.
- R11: A result checked in the same cycle as a limit write to its channel is compared with the limit value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convValid | input | 1 | A conversion result is present this cycle |
| convChan | input | 2 | Channel tag of the result |
| convData | input | 10 | Conversion result |
| monitorEn | input | 1 | Auto-monitor mode; results are checked only when 1 |
| limWrEn | input | 1 | Limit write strobe |
| limWrChan | input | 2 | Channel of the limit write |
| limWrUpper | input | 1 | 1 selects the upper limit, 0 the lower limit |
| limWrData | input | 10 | Limit value to write |
| limRdChan | input | 2 | Channel of the limit read |
| limRdUpper | input | 1 | 1 reads the upper limit, 0 the lower limit |
| limRdData | output | 10 | Selected limit value |
| clrEn | input | 1 | Fault clear strobe |
| clrMask | input | 3 | Channels to clear, bit i for channel i |
| alertOe | output | 1 | Pull-down enable for the open-drain alert line |
| faultStatus | output | 3 | Latched fault bits, bit i for channel i |

## Verification
Two situations are hard to reach from the ports, because each needs two independent inputs to collide in one cycle on the same channel. The first is a clear that lands on a channel while a new out-of-window result for that channel arrives. The second is a limit write that lands while a result for that channel is being checked. The stimulus lines these up on purpose. It drives `clrEn` together with a failing result, and a narrowing upper-limit write together with a result that only the new limit would reject. It then checks the following cycle, and in the second case also the cycle after, when the new limit does take effect.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  // Qualified strobes from the control decode to the datapath.
  typedef struct packed {
    logic sample;    // a result must be checked this cycle
    logic limWrite;  // a limit register must be written this cycle
    logic limUpper;  // limit write targets the upper bound
    logic clear;     // masked fault bits must be cleared
  } alarmStrobe_t;

endpackage

// File: rtl/alarm_window_cmp.sv
module alarm_window_cmp #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] upper,
  input  logic [DATA_W-1:0] lower,
  output logic              above,
  output logic              below
);

  // Strict comparisons: a value sitting on a bound is inside the window.
  assign above = value > upper;
  assign below = value < lower;

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic              convValid,
  input  logic [CH_W-1:0]   convChan,
  input  logic              monitorEn,
  input  logic              limWrEn,
  input  logic [CH_W-1:0]   limWrChan,
  input  logic              limWrUpper,
  input  logic              clrEn,
  output alarmStrobe_t      strb,
  output logic [NUM_CH-1:0] convHot,
  output logic [NUM_CH-1:0] wrHot
);

  localparam int CK_W = CH_W + 1;

  logic convChanOk;
  logic wrChanOk;

  assign convChanOk = {1'b0, convChan} < CK_W'(NUM_CH);
  assign wrChanOk   = {1'b0, limWrChan} < CK_W'(NUM_CH);

  assign strb.sample   = convValid && monitorEn && convChanOk;
  assign strb.limWrite = limWrEn && wrChanOk;
  assign strb.limUpper = limWrUpper;
  assign strb.clear    = clrEn;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign convHot[i] = convChan  == CH_W'(i);
    assign wrHot[i]   = limWrChan == CH_W'(i);
  end

  // R6: with monitoring off no sample strobe reaches the datapath
  a_r6_no_sample_when_off : assert final (monitorEn || !strb.sample);

endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int                NUM_CH    = 3,
  parameter int                DATA_W    = 10,
  parameter int                CH_W      = 2,
  parameter logic [DATA_W-1:0] RST_UPPER = '1,
  parameter logic [DATA_W-1:0] RST_LOWER = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  alarmStrobe_t      strb,
  input  logic [NUM_CH-1:0] convHot,
  input  logic [NUM_CH-1:0] wrHot,
  input  logic [DATA_W-1:0] convData,
  input  logic [DATA_W-1:0] limWrData,
  input  logic [NUM_CH-1:0] clrMask,
  input  logic [CH_W-1:0]   limRdChan,
  input  logic              limRdUpper,
  output logic [DATA_W-1:0] limRdData,
  output logic [NUM_CH-1:0] faultQ,
  output logic              alertOe
);

  logic [DATA_W-1:0] upperQ [NUM_CH];
  logic [DATA_W-1:0] lowerQ [NUM_CH];
  logic [NUM_CH-1:0] outside;
  logic [NUM_CH-1:0] sampleHit;
  logic [NUM_CH-1:0] writeHit;
  logic [NUM_CH-1:0] clearHit;
  logic [NUM_CH-1:0] faultNext;

  assign sampleHit = convHot & {NUM_CH{strb.sample}};
  assign writeHit  = wrHot & {NUM_CH{strb.limWrite}};
  assign clearHit  = clrMask & {NUM_CH{strb.clear}};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic above;
    logic below;

    alarm_window_cmp #(.DATA_W(DATA_W)) u_cmp (
      .value (convData),
      .upper (upperQ[i]),
      .lower (lowerQ[i]),
      .above (above),
      .below (below)
    );
    assign outside[i] = above || below;

    // R4: a result above the upper bound latches the fault
    a_r4_above_trips : assert property (@(posedge clk) disable iff (!rst_n)
      sampleHit[i] && (convData > upperQ[i]) |=> faultQ[i]);

    // R5: a result on the upper bound and not below the lower one leaves a clear fault clear
    a_r5_on_bound_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      sampleHit[i] && (convData == upperQ[i]) && (convData >= lowerQ[i]) && !faultQ[i]
      |=> !faultQ[i]);

    // R8: a latched fault holds unless its clear bit is requested
    a_r8_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      faultQ[i] && !clearHit[i] |=> faultQ[i]);

    // R2/R3: limits move only on a qualified write to this channel
    a_r3_limits_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !writeHit[i] |=> $stable(upperQ[i]) && $stable(lowerQ[i]));
  end

  // Set has priority over clear on the same channel (R9).
  assign faultNext = (faultQ & ~clearHit) | (sampleHit & outside);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        upperQ[i] <= RST_UPPER;
        lowerQ[i] <= RST_LOWER;
      end
      faultQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (writeHit[i]) begin
          if (strb.limUpper) upperQ[i] <= limWrData;
          else               lowerQ[i] <= limWrData;
        end
      end
      faultQ <= faultNext;
    end
  end

  always_comb begin
    limRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (limRdChan == CH_W'(i)) limRdData = limRdUpper ? upperQ[i] : lowerQ[i];
    end
  end

  assign alertOe = |faultQ;

  // R9: a failing sample survives a same-cycle clear of its channel
  a_r9_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
    (sampleHit & outside & clearHit) != '0 |=> (faultQ & $past(sampleHit & outside)) != '0);

endmodule

// File: rtl/window_alarm_monitor.sv
module window_alarm_monitor
  import alarm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 10,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convValid,
  input  logic [CH_W-1:0]   convChan,
  input  logic [DATA_W-1:0] convData,
  input  logic              monitorEn,
  input  logic              limWrEn,
  input  logic [CH_W-1:0]   limWrChan,
  input  logic              limWrUpper,
  input  logic [DATA_W-1:0] limWrData,
  input  logic [CH_W-1:0]   limRdChan,
  input  logic              limRdUpper,
  output logic [DATA_W-1:0] limRdData,
  input  logic              clrEn,
  input  logic [NUM_CH-1:0] clrMask,
  output logic              alertOe,
  output logic [NUM_CH-1:0] faultStatus
);

  alarmStrobe_t      strb;
  logic [NUM_CH-1:0] convHot;
  logic [NUM_CH-1:0] wrHot;

  alarm_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .convValid  (convValid),
    .convChan   (convChan),
    .monitorEn  (monitorEn),
    .limWrEn    (limWrEn),
    .limWrChan  (limWrChan),
    .limWrUpper (limWrUpper),
    .clrEn      (clrEn),
    .strb       (strb),
    .convHot    (convHot),
    .wrHot      (wrHot)
  );

  alarm_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .convHot    (convHot),
    .wrHot      (wrHot),
    .convData   (convData),
    .limWrData  (limWrData),
    .clrMask    (clrMask),
    .limRdChan  (limRdChan),
    .limRdUpper (limRdUpper),
    .limRdData  (limRdData),
    .faultQ     (faultStatus),
    .alertOe    (alertOe)
  );

  // R6: no fault bit rises in the cycle after monitoring was off
  a_r6_monitor_off : assert property (@(posedge clk) disable iff (!rst_n)
    !monitorEn |=> (faultStatus & ~$past(faultStatus)) == '0);

  // R10: the alert can only start after a monitored result
  a_r10_alert_cause : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alertOe) |-> $past(convValid && monitorEn));

endmodule

// File: tb/window_alarm_monitor_test.sv
`timescale 1ns/1ps
module window_alarm_monitor_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       convValid = 0, monitorEn = 0, limWrEn = 0, limWrUpper = 0;
  logic       limRdUpper = 0, clrEn = 0;
  logic [1:0] convChan = 0, limWrChan = 0, limRdChan = 0;
  logic [9:0] convData = 0, limWrData = 0;
  logic [2:0] clrMask = 0;
  logic [9:0] limRdData;
  logic       alertOe;
  logic [2:0] faultStatus;

  window_alarm_monitor uut (
    .clk(clk), .rst_n(rst_n), .convValid(convValid), .convChan(convChan),
    .convData(convData), .monitorEn(monitorEn), .limWrEn(limWrEn),
    .limWrChan(limWrChan), .limWrUpper(limWrUpper), .limWrData(limWrData),
    .limRdChan(limRdChan), .limRdUpper(limRdUpper), .limRdData(limRdData),
    .clrEn(clrEn), .clrMask(clrMask), .alertOe(alertOe), .faultStatus(faultStatus)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0] faults;
    logic       alert;
    logic [9:0] rd;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       checks = 0;
  int       errors = 0;
  bit       finished = 0;

  int         mUp [3];
  int         mLo [3];
  logic [2:0] mFault;

  task automatic step(input logic cv, input logic [1:0] cch, input int cd, input logic mon,
                      input logic we, input logic [1:0] wch, input logic wup, input int wd,
                      input logic [1:0] rch, input logic rup,
                      input logic clr, input logic [2:0] cm, input string tag);
    expItem_t e;
    logic [2:0] setv;
    @(negedge clk);
    convValid = cv; convChan = cch; convData = cd[9:0]; monitorEn = mon;
    limWrEn = we; limWrChan = wch; limWrUpper = wup; limWrData = wd[9:0];
    limRdChan = rch; limRdUpper = rup; clrEn = clr; clrMask = cm;
    setv = '0;
    if (cv && mon && cch < 3)
      if (cd > mUp[cch] || cd < mLo[cch]) setv[cch] = 1'b1;
    mFault = (mFault & ~(clr ? cm : 3'b000)) | setv;
    if (we && wch < 3) begin
      if (wup) mUp[wch] = wd; else mLo[wch] = wd;
    end
    e.faults = mFault;
    e.alert  = |mFault;
    e.rd     = (rch < 3) ? 10'(rup ? mUp[rch] : mLo[rch]) : 10'd0;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic conv(input logic [1:0] ch, input int d, input logic mon, input string tag);
    step(1, ch, d, mon, 0, 0, 0, 0, 0, 1, 0, 3'b000, tag);
  endtask

  task automatic wrLim(input logic [1:0] ch, input logic up, input int d, input string tag);
    step(0, 0, 0, 1, 1, ch, up, d, ch, up, 0, 3'b000, tag);
  endtask

  task automatic rdLim(input logic [1:0] ch, input logic up, input string tag);
    step(0, 0, 0, 1, 0, 0, 0, 0, ch, up, 0, 3'b000, tag);
  endtask

  task automatic clr(input logic [2:0] cm, input string tag);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, cm, tag);
  endtask

  // Monitor: compare each expected item after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (faultStatus !== e.faults || alertOe !== e.alert || limRdData !== e.rd) begin
          errors++;
          $display("FAIL %s: faults=%b alert=%b rd=%0d expected faults=%b alert=%b rd=%0d",
                   t, faultStatus, alertOe, limRdData, e.faults, e.alert, e.rd);
        end
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mUp[i] = 1023; mLo[i] = 0; end
    mFault = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values seen through the read port and the outputs
    rdLim(0, 1, "R1 upper reset");
    rdLim(2, 0, "R1 lower reset");
    conv(0, 1023, 1, "R1 all-pass window");
    conv(2, 0, 1, "R1 all-pass window low");
    // R2: writes to both bounds
    wrLim(0, 1, 600, "R2 write upper");
    wrLim(0, 0, 200, "R2 write lower");
    wrLim(1, 0, 100, "R2 write lower ch1");
    // R3: out-of-range channel
    wrLim(3, 1, 5, "R3 write ch3 ignored");
    rdLim(0, 1, "R3 ch0 upper intact");
    rdLim(1, 1, "R3 ch1 upper intact");
    rdLim(2, 1, "R3 ch2 upper intact");
    // R5: values on the bounds
    conv(0, 600, 1, "R5 equal upper");
    conv(0, 200, 1, "R5 equal lower");
    conv(1, 100, 1, "R5 equal lower ch1");
    // R6: monitoring off
    conv(0, 601, 0, "R6 off no fault");
    // R7: tag beyond channel count
    conv(3, 50, 1, "R7 tag 3 ignored");
    // R4 and R10
    conv(0, 601, 1, "R4 above upper");
    conv(0, 300, 1, "R8 sticky after good value");
    conv(1, 50, 0, "R6 off keeps latched");
    conv(1, 99, 1, "R4 below lower ch1");
    // R8: masked clear
    clr(3'b001, "R8 clear ch0 only");
    // R9: set wins
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, 1, 1, 3'b011, "R9 set beats clear");
    clr(3'b010, "R10 alert released");
    // R11: same-cycle write and compare
    step(1, 2, 500, 1, 1, 2, 1, 10, 2, 1, 0, 3'b000, "R11 old limit used");
    conv(2, 500, 1, "R11 new limit used");
    conv(2, 10, 1, "R5 equal new upper");
    clr(3'b111, "R8 clear all");
    conv(0, 1000, 1, "R10 alert again");
    repeat (3) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1;
      if (expQ.size() != 0) begin
        errors++;
        $display("FAIL drain: %0d items left, expected 0", expQ.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule